// File: doc/BRIEF.md
# Reset-Time Serial Clock-Mask Loader

This block runs a short, fixed sequence each time the upstream reset is released. For that sequence it takes over the general-purpose I/O pins and uses them to drive an external parallel-in, serial-out shift register. One pin pulses a load command. Another pin toggles as the shift clock. The mask bits come back one at a time on a dedicated serial input and are collected into a 16-bit clock-disable mask. Each set bit of that mask switches off one downstream clock output.

The downstream reset stays asserted while the sequence runs. After a fixed budget of 23 clock cycles, the block raises `done_o`, places the collected bits on the mask outputs and releases the downstream reset. From that cycle on, the pins carry the values and enables of the ordinary GPIO register bank.

The shift clock on pin 0 is high during the low half of the system clock in each shift cycle. This puts its rising edge at the falling edge of the system clock, so the serial input settles for half a cycle before the block samples it on the rising edge.

Top module: `clkmask_loader`

## Requirements
- R1: While `rst_n` is low, `done_o` is 0, `srst_n` is 0 and `clk_off` is all zeros (every clock enabled). The pins are in load mode: `pin_do[2]`=0, `pin_oe`=4'b0101.
- R2: Number the cycles after `rst_n` is released as k=0,1,2,… with k=0 ending at the first rising clock edge. `pin_do[2]` (load/shift control, 0 = load, 1 = shift) is 0 in cycle 0 and 1 in cycles 1 to 22.
- R3: `pin_do[0]` (shift clock) is high only during the low half of the clock in cycles 2 to 17, which gives exactly 16 rising edges per sequence. It is low in the high half of every cycle and in all other cycles of the sequence.
- R4: `ser_in` is sampled at the rising edges that end cycles 1 to 16. The first sample becomes `clk_off[15]` (MSB) and the last becomes `clk_off[0]`. A 1 in `clk_off[i]` disables downstream clock i.
- R5: While the sequence runs, `pin_oe` is 4'b0101: pins 0 and 2 are driven and pins 1 and 3 are tri-stated, whatever the GPIO register bank holds. `pin_do[1]` and `pin_do[3]` are 0.
- R6: `done_o` rises at the edge ending cycle 22, so it is first seen high in cycle 23. It then stays high until the next reset.
- R7: `clk_off` stays all zeros until `done_o` rises. It takes the captured value in that same edge and afterwards does not change, even if `ser_in` or the pins toggle.
- R8: `srst_n` is `done_o` AND NOT `sec_rst_req`. A downstream reset request after completion asserts `srst_n` low but does not restart loading or disturb `clk_off`.
- R9: Once `done_o` is high, `pin_do` equals `gp_do` and `pin_oe` equals `gp_oe`.
- R10: If `rst_n` is asserted part-way through a sequence, the sequence is abandoned. After the next release a complete fresh 23-cycle sequence runs and captures a new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Upstream reset, active low, asynchronous assert |
| sec_rst_req | input | 1 | Request to hold the downstream reset asserted |
| ser_in | input | 1 | Serial mask data from the external shift register |
| gp_do | input | 4 | Output values from the GPIO register bank |
| gp_oe | input | 4 | Output enables from the GPIO register bank |
| pin_do | output | 4 | Values driven onto the GPIO pins |
| pin_oe | output | 4 | Output enables of the GPIO pins |
| clk_off | output | 16 | Clock-disable mask, 1 = clock off |
| done_o | output | 1 | High once the mask has been loaded |
| srst_n | output | 1 | Downstream reset, active low |

## Verification
Two events can land on the same clock edge. One is the end of the loading sequence: the mask capture, the release of the downstream reset and the pin handover. The other is a downstream reset request arriving from outside. To provoke the overlap, the bench holds `sec_rst_req` high across the completing edge. It then expects `srst_n` to stay low, `done_o` to rise on schedule, the mask to carry the full captured pattern and the pins to switch to the register bank, all in the same cycle. Dropping the request later must release `srst_n` with the mask untouched.

// File: rtl/clkmask_loader.sv
module clkmask_loader #(
  parameter int MASK_W     = 16,
  parameter int SEQ_CYCLES = 23,
  parameter int GPIO_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_rst_req,
  input  logic              ser_in,
  input  logic [GPIO_W-1:0] gp_do,
  input  logic [GPIO_W-1:0] gp_oe,
  output logic [GPIO_W-1:0] pin_do,
  output logic [GPIO_W-1:0] pin_oe,
  output logic [MASK_W-1:0] clk_off,
  output logic              done_o,
  output logic              srst_n
);

  localparam int CW       = $clog2(SEQ_CYCLES + 1);
  localparam int CAP_LO   = 1;
  localparam int CAP_HI   = MASK_W;
  localparam int LAST_CYC = SEQ_CYCLES - 1;
  localparam int SCLK_PIN = 0;
  localparam int LDSH_PIN = 2;

  logic [CW-1:0]     cnt;
  logic [MASK_W-1:0] shreg;
  logic              win_q;
  logic              capture;
  logic              sclk;
  logic              ld_sh;

  assign capture = !done_o && (cnt >= CW'(CAP_LO)) && (cnt <= CW'(CAP_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      shreg   <= '0;
      win_q   <= 1'b0;
      done_o  <= 1'b0;
      clk_off <= '0;
    end else if (!done_o) begin
      cnt   <= cnt + 1'b1;
      win_q <= capture;
      if (capture) shreg <= {shreg[MASK_W-2:0], ser_in};
      if (cnt == CW'(LAST_CYC)) begin
        done_o  <= 1'b1;
        clk_off <= shreg;
      end
    end else begin
      win_q <= 1'b0;
    end
  end

  assign sclk  = win_q & ~clk;
  assign ld_sh = (cnt != '0);

  always_comb begin
    if (done_o) begin
      pin_do = gp_do;
      pin_oe = gp_oe;
    end else begin
      pin_do           = '0;
      pin_oe           = '0;
      pin_do[SCLK_PIN] = sclk;
      pin_do[LDSH_PIN] = ld_sh;
      pin_oe[SCLK_PIN] = 1'b1;
      pin_oe[LDSH_PIN] = 1'b1;
    end
  end

  assign srst_n = done_o & ~sec_rst_req;

  initial begin
    assert (SEQ_CYCLES >= MASK_W + 3) else $error("sequence budget too short");
    assert (GPIO_W > LDSH_PIN) else $error("too few GPIO pins");
  end

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  p_count_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (cnt == $past(cnt) + 1'b1));

  p_mask_only_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_off) |-> $rose(done_o));

  p_mask_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(clk_off));

  p_reset_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !srst_n);

  p_spare_pins_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (pin_oe == 4'b0101));

  p_no_shift_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_o) |-> !win_q);

endmodule

// File: tb/clkmask_loader_tb_top.sv
module clkmask_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_rst_req = 1'b0;
  logic        ser_in;
  logic [3:0]  gp_do = 4'h0;
  logic [3:0]  gp_oe = 4'h0;
  logic [3:0]  pin_do, pin_oe;
  logic [15:0] clk_off;
  logic        done_o, srst_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] ext = 16'h0;
  logic [15:0] pattern = 16'h0;
  int edges = 0;

  always #4 clk = ~clk;

  clkmask_loader dut_i (
    .clk(clk), .rst_n(rst_n), .sec_rst_req(sec_rst_req), .ser_in(ser_in),
    .gp_do(gp_do), .gp_oe(gp_oe), .pin_do(pin_do), .pin_oe(pin_oe),
    .clk_off(clk_off), .done_o(done_o), .srst_n(srst_n)
  );

  // external parallel-in serial-out register model
  assign ser_in = ext[15];
  always @(negedge clk) if (pin_oe[2] && !pin_do[2]) ext = pattern;
  always @(posedge pin_do[0]) begin
    edges++;
    if (pin_do[2]) ext = {ext[14:0], 1'b0};
  end

  function automatic logic exp_ldsh(int k);
    return (k != 0);
  endfunction
  function automatic logic exp_sclk_low_half(int k);
    return (k >= 2 && k <= 17);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // sequence from release; abort_k>0 reasserts reset at that cycle
  task automatic run_seq(logic [15:0] pat, int abort_k, bit hold_req);
    logic [3:0] bank_do, bank_oe;
    bank_do = 4'($urandom) & 4'b1110;
    bank_oe = 4'($urandom) | 4'b1010;
    pattern = pat;
    gp_do = bank_do; gp_oe = bank_oe;
    sec_rst_req = hold_req;
    rst_n = 1'b0;
    @(posedge clk); #2;
    chk(done_o == 0 && srst_n == 0, "R1", {done_o, srst_n}, 0);
    chk(clk_off == 0, "R1", clk_off, 0);
    chk(pin_do[2] == 0 && pin_oe == 4'b0101, "R1", {pin_do, pin_oe}, 8'h05);
    edges = 0;
    rst_n = 1'b1;
    for (int k = 0; k <= 24; k++) begin
      if (abort_k != 0 && k == abort_k) begin
        rst_n = 1'b0;
        #1;
        chk(done_o == 0 && clk_off == 0, "R10", clk_off, 0);
        return;
      end
      if (k < 23) begin
        chk(pin_do[2] == exp_ldsh(k), "R2", pin_do[2], exp_ldsh(k));
        chk(pin_do[0] == 0, "R3", pin_do[0], 0);
        chk(pin_oe == 4'b0101 && pin_do[3] == 0 && pin_do[1] == 0, "R5", {pin_do, pin_oe}, 4'b0101);
        chk(done_o == 0 && srst_n == 0, "R6", {done_o, srst_n}, 0);
        chk(clk_off == 0, "R7", clk_off, 0);
      end else begin
        chk(done_o == 1, "R6", done_o, 1);
        chk(clk_off == pat, "R4", clk_off, pat);
        chk(srst_n == !hold_req, "R8", srst_n, !hold_req);
        chk(pin_do == bank_do && pin_oe == bank_oe, "R9", {pin_do, pin_oe}, {bank_do, bank_oe});
      end
      if (k == 23) chk(edges == 16, "R3", edges, 16);
      @(negedge clk); #1;
      if (k < 23)
        chk(pin_do[0] == exp_sclk_low_half(k), "R3", pin_do[0], exp_sclk_low_half(k));
      @(posedge clk); #2;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    run_seq(16'h8001, 0, 0);
    run_seq(16'hFFFF, 0, 0);
    run_seq(16'h0000, 0, 0);
    run_seq(16'h5A3C, 0, 0);
    for (int i = 0; i < 6; i++) run_seq(16'($urandom), 0, 0);

    // completion coinciding with a downstream reset request
    run_seq(16'hC0DE, 0, 1);
    sec_rst_req = 1'b0; #1;
    chk(srst_n == 1 && clk_off == 16'hC0DE, "R8", {srst_n, clk_off}, {1'b1, 16'hC0DE});

    // after completion: request and pin activity leave the mask alone
    gp_oe = 4'hF;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      gp_do = 4'($urandom);
      sec_rst_req = (i % 3 == 0);
      #1;
      chk(srst_n == !sec_rst_req, "R8", srst_n, !sec_rst_req);
      chk(clk_off == 16'hC0DE && done_o, "R7", clk_off, 16'hC0DE);
    end
    sec_rst_req = 1'b0;

    // abort mid-sequence then full reload
    run_seq(16'h1234, 9, 0);
    run_seq(16'hBEEF, 0, 0);
    run_seq(16'h7777, 20, 0);
    run_seq(16'h0F0F, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule